// File: doc/BRIEF.md
# Target Read Latency and Delayed-Read Controller

This block runs the target side of memory read transactions on a parallel bus. An abstracted bus front end supplies each new access as a one-cycle request strobe together with a command code, an address and byte enables. The block answers in one of four ways: it inserts wait states, it terminates the access with a retry, it streams data words, or it disconnects. On the application side the block exposes a pending request record (valid flag, address, byte enables). The application answers that record by writing words into an internal read FIFO.

A mode input selects between two ways of working. In delayed operation the first read is always retried and its parameters are latched, so the application can fetch the data in the background. A later read whose address and byte enables match is then served from the FIFO. In non-delayed operation the access is held with wait states for up to 16 or 32 clocks, chosen by a select input, while the application fills the FIFO. If data arrives in time it flows out in the same access. If it does not, the block retries the access, keeps the record and serves a later matching attempt. A burst runs until the master signals its final word or the FIFO runs dry. Completing a request clears the record and discards any words left in the FIFO.

Top module: `tgt_rdlat_ctrl`

## Requirements
- R1: Only command code 4'b0110 (memory read) is acted on; any other code, including the reserved codes 4'b0100 and 4'b0101, produces no wait, retry, data or disconnect and leaves the pending record unchanged.
- R2: In delayed mode (`mode_delayed`=1), a memory read arriving with no pending record raises `tgt_retry` for one cycle in the cycle after the request, and latches its address and byte enables onto `pend_addr`/`pend_be` with `pend_valid`=1.
- R3: While a record is pending and the FIFO is empty, every memory read is retried. A read whose address and byte enables both equal the record, arriving while the FIFO holds data, starts streaming in the cycle after the request.
- R4: A memory read whose address or byte enables differ from a pending record is retried, and the record stays unchanged.
- R5: In non-delayed mode, a memory read with no pending record raises `tgt_wait` starting in the next cycle. If the FIFO becomes non-empty before the limit expires, the same access moves on to streaming with no retry.
- R6: The wait limit is 16 cycles when `lat_sel`=0 and 32 cycles when `lat_sel`=1. After exactly that many `tgt_wait` cycles with the FIFO still empty, `tgt_retry` pulses once and the record stays pending. A later matching read is then served as in R3.
- R7: While streaming, the block gives one FIFO word per cycle on `tgt_data` with `tgt_dvalid`=1, in write order. The burst ends after the word during which `bus_mend` is high. If the FIFO is empty instead, it ends with a single `tgt_disc` cycle that carries no data. At most one of `tgt_wait`, `tgt_retry`, `tgt_dvalid` and `tgt_disc` is high in any cycle.
- R8: When a burst ends, `pend_valid` drops in the next cycle, the block returns to idle, and any unread FIFO words are discarded.
- R9: The FIFO holds `FIFO_DEPTH` words. `fifo_full` is high when it holds that many, and application writes made while it is full are dropped.
- R10: Under reset all termination outputs, `pend_valid` and `fifo_full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_delayed | input | 1 | 1: delayed operation, 0: wait-state operation |
| lat_sel | input | 1 | Wait limit select: 0 gives 16 cycles, 1 gives 32 cycles |
| bus_req | input | 1 | One-cycle strobe marking a new access |
| bus_cmd | input | 4 | Command code of the access |
| bus_addr | input | AW | Address of the access |
| bus_be | input | BEW | Byte enables of the access |
| bus_mend | input | 1 | Master takes its final word this cycle |
| tgt_wait | output | 1 | Wait state inserted |
| tgt_retry | output | 1 | Access terminated with retry |
| tgt_disc | output | 1 | Burst disconnected, no data this cycle |
| tgt_dvalid | output | 1 | `tgt_data` carries a word |
| tgt_data | output | DW | Read data word |
| pend_valid | output | 1 | Pending request record is valid |
| pend_addr | output | AW | Address of the pending request |
| pend_be | output | BEW | Byte enables of the pending request |
| app_wr | input | 1 | Application writes a word into the read FIFO |
| app_wdata | input | DW | Word written by the application |
| fifo_full | output | 1 | Read FIFO is full |

## Verification
The bench drives several request patterns. Reserved and foreign command codes show that ignored accesses leave the outputs and the record untouched. Repeated matching reads against an empty FIFO separate "retry until loaded" from early streaming, and reads that differ only in address or only in byte enables show that the match needs both fields. In wait-state mode, data written a few cycles into the wait shows same-access delivery, while no data at all with each limit setting counts the exact 16 and 32 wait cycles before the retry. Bursts that end by the master's final-word strobe, and bursts that end by the FIFO running dry (including one after the FIFO was overfilled), show the two ending paths, the drop of writes when full, and the discard of unread words.

// File: rtl/rdl_pkg.sv
package rdl_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RETRY = 2'd2,
    ST_XFER  = 2'd3
  } rdl_state_e;

  localparam logic [3:0] CMD_MEM_READ = 4'b0110;

  function automatic logic is_mem_read(input logic [3:0] cmd);
    return cmd == CMD_MEM_READ;
  endfunction

  function automatic int unsigned lat_limit(input logic sel,
                                            input int unsigned short_lim,
                                            input int unsigned long_lim);
    return sel ? long_lim : short_lim;
  endfunction
endpackage

// File: rtl/rdl_fifo.sv
module rdl_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          flush,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign push  = wr_en && !full && !flush;
  assign pop   = rd_en && !empty && !flush;
  assign rd_data = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  // R9: a write into a full FIFO with no read must leave it full
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !flush) |=> full);

  // R9: occupancy never exceeds the depth
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R8: a flush leaves the FIFO empty
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/rdl_req_rec.sv
module rdl_req_rec #(
  parameter int AW  = 32,
  parameter int BEW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           clear,
  input  logic [AW-1:0]  in_addr,
  input  logic [BEW-1:0] in_be,
  output logic           valid,
  output logic [AW-1:0]  addr,
  output logic [BEW-1:0] be,
  output logic           hit
);
  timeunit 1ns;
  timeprecision 1ps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      be    <= '0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= in_addr;
      be    <= in_be;
    end
  end

  assign hit = valid && (in_addr == addr) && (in_be == be);

  // R4: an untouched record keeps its contents
  assert_record_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !load && !clear) |=> (valid && $stable(addr) && $stable(be)));
endmodule

// File: rtl/rdl_ctrl.sv
module rdl_ctrl
  import rdl_pkg::*;
#(
  parameter int LAT_SHORT = 16,
  parameter int LAT_LONG  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_delayed,
  input  logic       lat_sel,
  input  logic       bus_req,
  input  logic [3:0] bus_cmd,
  input  logic       bus_mend,
  input  logic       rec_valid,
  input  logic       rec_hit,
  input  logic       fifo_empty,
  output logic       st_idle,
  output logic       rec_load,
  output logic       done,
  output logic       pop,
  output logic       o_wait,
  output logic       o_retry,
  output logic       o_dvalid,
  output logic       o_disc
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = $clog2(LAT_LONG + 1);

  rdl_state_e    st, nxt;
  logic [CW-1:0] cnt, cnt_nxt, lim;
  logic          rd_evt, lim_hit;

  assign lim     = CW'(lat_limit(lat_sel, LAT_SHORT, LAT_LONG));
  assign lim_hit = (cnt >= lim - CW'(1));
  assign rd_evt  = (st == ST_IDLE) && bus_req && is_mem_read(bus_cmd);

  always_comb begin
    nxt      = st;
    cnt_nxt  = cnt;
    rec_load = 1'b0;
    case (st)
      ST_IDLE: begin
        if (rd_evt) begin
          if (rec_valid) begin
            nxt = (rec_hit && !fifo_empty) ? ST_XFER : ST_RETRY;
          end else begin
            rec_load = 1'b1;
            if (mode_delayed) begin
              nxt = ST_RETRY;
            end else begin
              nxt     = ST_WAIT;
              cnt_nxt = '0;
            end
          end
        end
      end
      ST_WAIT: begin
        if (!fifo_empty)  nxt = ST_XFER;
        else if (lim_hit) nxt = ST_RETRY;
        else              cnt_nxt = cnt + CW'(1);
      end
      ST_RETRY: nxt = ST_IDLE;
      ST_XFER: begin
        if (fifo_empty || bus_mend) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= nxt;
      cnt <= cnt_nxt;
    end
  end

  assign st_idle  = (st == ST_IDLE);
  assign done     = (st == ST_XFER) && (fifo_empty || bus_mend);
  assign pop      = (st == ST_XFER) && !fifo_empty;
  assign o_wait   = (st == ST_WAIT);
  assign o_retry  = (st == ST_RETRY);
  assign o_dvalid = (st == ST_XFER) && !fifo_empty;
  assign o_disc   = (st == ST_XFER) && fifo_empty;

  // R7: never more than one bus response at a time
  assert_one_response_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({o_wait, o_retry, o_dvalid, o_disc}));

  // R1: a non-read command seen in idle keeps the controller idle
  assert_ignore_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && bus_req && !is_mem_read(bus_cmd)) |=> st_idle);

  // R2: delayed mode retries a fresh read
  assert_delayed_retry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !rec_valid && mode_delayed) |=> o_retry);

  // R6: the last empty wait cycle leads to a retry
  assert_timeout_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_wait && fifo_empty && lim_hit) |=> o_retry);

  // R7: a finished burst returns to idle
  assert_burst_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> st_idle);
endmodule

// File: rtl/tgt_rdlat_ctrl.sv
module tgt_rdlat_ctrl
  import rdl_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int BEW        = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int LAT_SHORT  = 16,
  parameter int LAT_LONG   = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_delayed,
  input  logic           lat_sel,
  input  logic           bus_req,
  input  logic [3:0]     bus_cmd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [BEW-1:0] bus_be,
  input  logic           bus_mend,
  output logic           tgt_wait,
  output logic           tgt_retry,
  output logic           tgt_disc,
  output logic           tgt_dvalid,
  output logic [DW-1:0]  tgt_data,
  output logic           pend_valid,
  output logic [AW-1:0]  pend_addr,
  output logic [BEW-1:0] pend_be,
  input  logic           app_wr,
  input  logic [DW-1:0]  app_wdata,
  output logic           fifo_full
);
  timeunit 1ns;
  timeprecision 1ps;

  logic st_idle, rec_load, xfer_done, fifo_pop, fifo_empty, rec_hit;

  rdl_req_rec #(.AW(AW), .BEW(BEW)) u_rec (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rec_load),
    .clear   (xfer_done),
    .in_addr (bus_addr),
    .in_be   (bus_be),
    .valid   (pend_valid),
    .addr    (pend_addr),
    .be      (pend_be),
    .hit     (rec_hit)
  );

  rdl_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (app_wr),
    .wr_data (app_wdata),
    .rd_en   (fifo_pop),
    .flush   (xfer_done),
    .rd_data (tgt_data),
    .empty   (fifo_empty),
    .full    (fifo_full)
  );

  rdl_ctrl #(.LAT_SHORT(LAT_SHORT), .LAT_LONG(LAT_LONG)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_delayed (mode_delayed),
    .lat_sel      (lat_sel),
    .bus_req      (bus_req),
    .bus_cmd      (bus_cmd),
    .bus_mend     (bus_mend),
    .rec_valid    (pend_valid),
    .rec_hit      (rec_hit),
    .fifo_empty   (fifo_empty),
    .st_idle      (st_idle),
    .rec_load     (rec_load),
    .done         (xfer_done),
    .pop          (fifo_pop),
    .o_wait       (tgt_wait),
    .o_retry      (tgt_retry),
    .o_dvalid     (tgt_dvalid),
    .o_disc       (tgt_disc)
  );

  // R4: a mismatching read is retried and the record survives it
  assert_miss_retry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && bus_req && is_mem_read(bus_cmd) && pend_valid && !rec_hit)
    |=> (tgt_retry && pend_valid && $stable(pend_addr) && $stable(pend_be)));

  // R3: data only flows against a valid record
  assert_data_has_record_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_dvalid |-> pend_valid);

  // R8: completion clears the record
  assert_clear_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !pend_valid);
endmodule

// File: tb/tgt_rdlat_ctrl_tb.sv
module tgt_rdlat_ctrl_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 32, DW = 32, BEW = 4, DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_delayed = 1'b1, lat_sel = 1'b0;
  logic bus_req = 1'b0, bus_mend = 1'b0, app_wr = 1'b0;
  logic [3:0] bus_cmd = 4'h0;
  logic [AW-1:0] bus_addr = '0;
  logic [BEW-1:0] bus_be = '0;
  logic [DW-1:0] app_wdata = '0;
  logic tgt_wait, tgt_retry, tgt_disc, tgt_dvalid, pend_valid, fifo_full;
  logic [DW-1:0] tgt_data;
  logic [AW-1:0] pend_addr;
  logic [BEW-1:0] pend_be;

  always #10 clk = ~clk;

  tgt_rdlat_ctrl #(.AW(AW), .DW(DW), .BEW(BEW), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_delayed(mode_delayed), .lat_sel(lat_sel),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_mend(bus_mend), .tgt_wait(tgt_wait), .tgt_retry(tgt_retry),
    .tgt_disc(tgt_disc), .tgt_dvalid(tgt_dvalid), .tgt_data(tgt_data),
    .pend_valid(pend_valid), .pend_addr(pend_addr), .pend_be(pend_be),
    .app_wr(app_wr), .app_wdata(app_wdata), .fifo_full(fifo_full)
  );

  int checks = 0, fails = 0;
  string cur_req = "R10";
  bit cmp_on = 1'b0;
  int n_got, n_wait, n_retry, n_disc;

  // Behavioural model: 0 idle, 1 waiting, 2 retry, 3 streaming
  int m_st, m_cnt;
  bit m_rv;
  logic [AW-1:0] m_ra;
  logic [BEW-1:0] m_rbe;
  logic [DW-1:0] m_q[$];

  always @(posedge clk or negedge rst_n) begin
    int sz, lim, nst;
    bit rd, hit, fin;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_rv = 0; m_ra = '0; m_rbe = '0; m_q.delete();
    end else begin
      sz  = m_q.size();
      rd  = bus_req && (bus_cmd == 4'b0110);
      hit = m_rv && (bus_addr == m_ra) && (bus_be == m_rbe);
      lim = lat_sel ? 32 : 16;
      fin = 0;
      nst = m_st;
      case (m_st)
        0: if (rd) begin
             if (m_rv) nst = (hit && sz > 0) ? 3 : 2;
             else begin
               m_rv = 1; m_ra = bus_addr; m_rbe = bus_be;
               if (mode_delayed) nst = 2;
               else begin nst = 1; m_cnt = 0; end
             end
           end
        1: if (sz > 0) nst = 3;
           else if (m_cnt >= lim - 1) nst = 2;
           else m_cnt++;
        2: nst = 0;
        default: begin fin = (sz == 0) || bus_mend; if (fin) nst = 0; end
      endcase
      if (fin) begin
        m_q.delete(); m_rv = 0;
      end else begin
        if (m_st == 3 && sz > 0) void'(m_q.pop_front());
        if (app_wr && sz < DEPTH) m_q.push_back(app_wdata);
      end
      m_st = nst;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit ew, er, edv, edc, ef;
    ew = (m_st == 1); er = (m_st == 2);
    edv = (m_st == 3) && (m_q.size() > 0);
    edc = (m_st == 3) && (m_q.size() == 0);
    ef = (m_q.size() == DEPTH);
    chk({tgt_wait, tgt_retry, tgt_dvalid, tgt_disc, pend_valid, fifo_full} ==
        {ew, er, edv, edc, m_rv, ef}, cur_req, "flags",
        {tgt_wait, tgt_retry, tgt_dvalid, tgt_disc, pend_valid, fifo_full},
        {ew, er, edv, edc, m_rv, ef});
    if (m_rv)
      chk(pend_addr == m_ra && pend_be == m_rbe, cur_req, "record",
          {pend_addr, 28'd0, pend_be}, {m_ra, 28'd0, m_rbe});
    if (edv) chk(tgt_data == m_q[0], cur_req, "data", tgt_data, m_q[0]);
  endtask

  task automatic tick();
    @(negedge clk);
    if (cmp_on) compare();
    if (tgt_dvalid) n_got++;
    if (tgt_wait) n_wait++;
    if (tgt_retry) n_retry++;
    if (tgt_disc) n_disc++;
  endtask

  task automatic clr();
    n_got = 0; n_wait = 0; n_retry = 0; n_disc = 0;
  endtask

  task automatic issue(logic [3:0] cmd, logic [AW-1:0] a, logic [BEW-1:0] be);
    bus_req = 1; bus_cmd = cmd; bus_addr = a; bus_be = be;
    tick();
    bus_req = 0; bus_cmd = 4'h0;
  endtask

  // run n cycles; raise the final-word strobe on the mend_at-th data word
  task automatic idle(int n, int mend_at);
    for (int k = 0; k < n; k++) begin
      bus_mend = tgt_dvalid && (n_got == mend_at);
      tick();
    end
    bus_mend = 0;
  endtask

  task automatic push_words(int n, logic [DW-1:0] base);
    for (int k = 0; k < n; k++) begin
      app_wr = 1; app_wdata = base + DW'(k);
      tick();
    end
    app_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({tgt_wait, tgt_retry, tgt_dvalid, tgt_disc, pend_valid, fifo_full} == 6'b0,
        "R10", "reset outputs",
        {tgt_wait, tgt_retry, tgt_dvalid, tgt_disc, pend_valid, fifo_full}, 0);
    rst_n = 1; cmp_on = 1;
    tick();

    // R1: reserved and other commands ignored
    cur_req = "R1"; mode_delayed = 1;
    issue(4'b0100, 32'h100, 4'hF);
    chk(!tgt_retry && !tgt_wait && !pend_valid, "R1", "code 0100", {tgt_retry, pend_valid}, 0);
    issue(4'b0101, 32'h100, 4'hF);
    chk(!tgt_retry && !tgt_wait && !pend_valid, "R1", "code 0101", {tgt_retry, pend_valid}, 0);
    issue(4'b0111, 32'h100, 4'hF);
    chk(!tgt_retry && !pend_valid, "R1", "code 0111", {tgt_retry, pend_valid}, 0);

    // R2: delayed first read retried and latched
    cur_req = "R2";
    issue(4'b0110, 32'h1000, 4'h3);
    chk(tgt_retry && pend_valid && pend_addr == 32'h1000 && pend_be == 4'h3, "R2", "latch",
        {tgt_retry, pend_valid, pend_addr}, {2'b11, 32'h1000});
    idle(1, 0);

    // R3: matching read with empty FIFO retried
    cur_req = "R3";
    issue(4'b0110, 32'h1000, 4'h3);
    chk(tgt_retry, "R3", "retry while empty", tgt_retry, 1);
    idle(1, 0);

    // R4: mismatch on address, then on byte enables
    cur_req = "R4";
    issue(4'b0110, 32'h1004, 4'h3);
    chk(tgt_retry && pend_addr == 32'h1000, "R4", "addr miss", pend_addr, 32'h1000);
    idle(1, 0);
    push_words(3, 32'hA000_0000);
    issue(4'b0110, 32'h1000, 4'h1);
    chk(tgt_retry && pend_be == 4'h3, "R4", "be miss", pend_be, 4'h3);
    idle(1, 0);

    // R3/R7: matching read streams until FIFO empties
    cur_req = "R7";
    clr();
    issue(4'b0110, 32'h1000, 4'h3);
    idle(6, 0);
    chk(n_got == 3 && n_disc == 1, "R7", "empty-ended burst", {n_got, n_disc}, {32'd3, 32'd1});
    chk(!pend_valid, "R8", "record cleared", pend_valid, 0);

    // R7/R8: master ends early, leftovers discarded
    cur_req = "R8";
    issue(4'b0110, 32'h2000, 4'hF);
    idle(1, 0);
    push_words(5, 32'hB000_0000);
    clr();
    issue(4'b0110, 32'h2000, 4'hF);
    idle(6, 2);
    chk(n_got == 2 && n_disc == 0, "R7", "master-ended burst", {n_got, n_disc}, {32'd2, 32'd0});
    mode_delayed = 0; lat_sel = 0;
    issue(4'b0110, 32'h3000, 4'hF);
    chk(tgt_wait && !tgt_dvalid, "R8", "FIFO flushed", {tgt_wait, tgt_dvalid}, 2'b10);

    // R6: timeout at 16 cycles
    cur_req = "R6";
    clr(); n_wait = 1;
    idle(24, 0);
    chk(n_wait == 16 && n_retry == 1, "R6", "16-cycle limit", {n_wait, n_retry}, {32'd16, 32'd1});
    chk(pend_valid && pend_addr == 32'h3000, "R6", "record kept", pend_addr, 32'h3000);
    push_words(2, 32'hC000_0000);
    clr();
    issue(4'b0110, 32'h3000, 4'hF);
    idle(5, 0);
    chk(n_got == 2, "R6", "later match served", n_got, 2);

    // R5: data arrives during wait states
    cur_req = "R5";
    clr();
    issue(4'b0110, 32'h4000, 4'h7);
    idle(4, 0);
    push_words(2, 32'hD000_0000);
    idle(6, 0);
    chk(n_got == 2 && n_retry == 0 && n_wait >= 5, "R5", "same-access delivery",
        {n_got, n_retry}, {32'd2, 32'd0});

    // R6: timeout at 32 cycles
    cur_req = "R6";
    lat_sel = 1;
    issue(4'b0110, 32'h5000, 4'hF);
    clr(); n_wait = 1;
    idle(40, 0);
    chk(n_wait == 32 && n_retry == 1, "R6", "32-cycle limit", {n_wait, n_retry}, {32'd32, 32'd1});
    push_words(1, 32'hE000_0000);
    issue(4'b0110, 32'h5000, 4'hF);
    idle(4, 0);

    // R9: overfill, then drain exactly DEPTH words
    cur_req = "R9";
    mode_delayed = 1;
    push_words(DEPTH + 2, 32'hF000_0000);
    chk(fifo_full, "R9", "full flag", fifo_full, 1);
    issue(4'b0110, 32'h6000, 4'hF);
    idle(1, 0);
    clr();
    issue(4'b0110, 32'h6000, 4'hF);
    idle(DEPTH + 3, 0);
    chk(n_got == DEPTH && n_disc == 1, "R9", "dropped writes", n_got, DEPTH);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule